// File: doc/BRIEF.md
# Clock Manager Reconfiguration Sequencer

This block turns one user command (a new output-divider code plus a target frequency range) into the ordered series of register accesses that a clock manager's dynamic register port needs. The port has an address, write data, read data, an enable strobe, a write strobe and a ready strobe. The block first writes the divider register. It then updates the frequency-range fields of the synthesizer and of the delay-locked loop. Each of these two updates reads the register, changes only the range bits and writes the word back, so every other bit keeps its value.

The divider code is the wanted divisor minus one. A code of zero has no meaning, so the block rejects it and touches nothing. The block reports when it is busy and when a sequence has finished. If the clock manager does not answer an access within a limit set on an input, the block abandons the sequence and raises an error flag.

Top module: `clkmgr_reconfig_seq`

## Requirements
- R1: After reset, busy, done, bad_cmd, err_timeout and port_en are all low.
- R2: A command with div_code 0 accepted while idle starts no port access and leaves busy low. It raises bad_cmd for exactly one cycle, in the cycle after the command.
- R3: The first access of a sequence begins in the cycle after the command. It is a write (port_we=1) to address 0x52, and its data is div_code zero-extended to 16 bits. Codes 1 to 31 stand for divide-by-2 to divide-by-32.
- R4: A sequence makes exactly five accesses, in this order: write 0x52, read 0x41, write 0x41, read 0x58, write 0x58.
- R5: The write to 0x41 carries the word read from 0x41 with bit 5 replaced by cmd_high (1 = high range, 0 = low range). All other bits are unchanged.
- R6: The write to 0x58 carries the word read from 0x58 with bits 7 and 6 both set to cmd_high. All other bits are unchanged.
- R7: Each access is a one-cycle port_en pulse. The next access starts in the cycle after port_rdy is seen. Read data is taken from port_rdata in the cycle where port_rdy is high.
- R8: done is high for one cycle, in the cycle after the port_rdy of the last write. busy is high from the cycle after the command up to and including that done cycle, and it is low in the cycle after done.
- R9: A command that arrives while busy is ignored. It neither restarts the sequence nor changes the code or range being written.
- R10: The block counts the cycles it waits after each access. If port_rdy has not come within tmo_limit of those cycles (a limit of 0 acts as 1), the sequence stops, busy falls and err_timeout rises. err_timeout stays high until the next valid command is accepted.
- R11: A port_rdy that arrives when no access is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_div_code | input | DIV_W (5) | Divider code: divisor minus one |
| cmd_high | input | 1 | Target range: 1 = high, 0 = low |
| tmo_limit | input | TMO_W (8) | Number of wait cycles allowed per access |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence has finished |
| bad_cmd | output | 1 | One-cycle pulse when a zero code is rejected |
| err_timeout | output | 1 | Sticky flag: the last sequence timed out |
| port_addr | output | 7 | Register address |
| port_en | output | 1 | Access strobe |
| port_we | output | 1 | Write strobe, qualified by port_en |
| port_wdata | output | 16 | Write data |
| port_rdata | input | 16 | Read data, valid together with port_rdy |
| port_rdy | input | 1 | Access-complete strobe |

## Verification
On every cycle, assertions check the one-cycle shape of port_en, done and bad_cmd. They also check that every accepted command opens with the divider write and that each accepted reply leads to the next step one cycle later. They check that the range writes change only the range bits of the captured word, and that a timeout leaves the block idle with the flag set. A bench model compares the outputs of each cycle and finds the rest. Only its scenarios show that the five addresses come in the right order when reply latency varies, and that a command arriving mid-sequence really leaves the written code alone. They also show that the timeout falls exactly on the tmo_limit boundary and that a stray ready while idle does nothing. The final contents of a modelled register file confirm the read-modify-write results.

// File: rtl/clkrc_pkg.sv
package clkrc_pkg;
  localparam int REG_AW = 7;
  localparam int DATA_W = 16;

  localparam logic [REG_AW-1:0] ADDR_DIV   = 7'h52;
  localparam logic [REG_AW-1:0] ADDR_SYNTH = 7'h41;
  localparam logic [REG_AW-1:0] ADDR_DLL   = 7'h58;

  localparam logic [DATA_W-1:0] MASK_SYNTH = 16'h0020;
  localparam logic [DATA_W-1:0] MASK_DLL   = 16'h00C0;

  typedef enum logic [2:0] {
    ST_DIV    = 3'd0,
    ST_RD_SYN = 3'd1,
    ST_WR_SYN = 3'd2,
    ST_RD_DLL = 3'd3,
    ST_WR_DLL = 3'd4
  } step_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_WAIT  = 2'd2,
    PH_FIN   = 2'd3
  } phase_e;

  function automatic logic [REG_AW-1:0] step_addr(step_e s);
    case (s)
      ST_DIV:               return ADDR_DIV;
      ST_RD_SYN, ST_WR_SYN: return ADDR_SYNTH;
      default:              return ADDR_DLL;
    endcase
  endfunction

  function automatic logic step_writes(step_e s);
    return (s == ST_DIV) || (s == ST_WR_SYN) || (s == ST_WR_DLL);
  endfunction

  function automatic logic [DATA_W-1:0] merge_bits(logic [DATA_W-1:0] word,
                                                   logic [DATA_W-1:0] mask,
                                                   logic hi);
    return (word & ~mask) | (hi ? mask : '0);
  endfunction
endpackage

// File: rtl/clkrc_tmo_timer.sv
module clkrc_tmo_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W:0] cnt_q;
  logic [TMO_W:0] cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;
  assign expired = tick && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart)          cnt_q <= '0;
    else if (tick && !expired) cnt_q <= cnt_inc;
  end

  // R10: the counter never gets ahead of the limit while waiting
  p_cnt_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $stable(limit) && !$past(restart)) |-> (cnt_q < {1'b0, limit}) || (limit == '0));
endmodule

// File: rtl/clkrc_access_fmt.sv
module clkrc_access_fmt
  import clkrc_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  step_e              step,
  input  logic [DIV_W-1:0]   code,
  input  logic               hi,
  input  logic [DATA_W-1:0]  held,
  output logic [REG_AW-1:0]  addr,
  output logic               we,
  output logic [DATA_W-1:0]  wdata
);
  localparam int PAD_W = DATA_W - DIV_W;

  always_comb begin
    addr = step_addr(step);
    we   = step_writes(step);
    case (step)
      ST_DIV:    wdata = {{PAD_W{1'b0}}, code};
      ST_WR_SYN: wdata = merge_bits(held, MASK_SYNTH, hi);
      ST_WR_DLL: wdata = merge_bits(held, MASK_DLL, hi);
      default:   wdata = '0;
    endcase
  end
endmodule

// File: rtl/clkmgr_reconfig_seq.sv
module clkmgr_reconfig_seq
  import clkrc_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int TMO_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [DIV_W-1:0]   cmd_div_code,
  input  logic               cmd_high,
  input  logic [TMO_W-1:0]   tmo_limit,
  output logic               busy,
  output logic               done,
  output logic               bad_cmd,
  output logic               err_timeout,
  output logic [REG_AW-1:0]  port_addr,
  output logic               port_en,
  output logic               port_we,
  output logic [DATA_W-1:0]  port_wdata,
  input  logic [DATA_W-1:0]  port_rdata,
  input  logic               port_rdy
);
  phase_e             phase_q;
  step_e              step_q;
  logic [DIV_W-1:0]   code_q;
  logic               hi_q;
  logic [DATA_W-1:0]  hold_q;
  logic               bad_q, err_q;

  // named internal events
  logic idle_now, accept, reject, ack, last_step, read_step, timed_out;

  assign idle_now  = (phase_q == PH_IDLE);
  assign accept    = idle_now && cmd_valid && (cmd_div_code != '0);
  assign reject    = idle_now && cmd_valid && (cmd_div_code == '0);
  assign ack       = (phase_q == PH_WAIT) && port_rdy;
  assign last_step = (step_q == ST_WR_DLL);
  assign read_step = !step_writes(step_q);

  clkrc_tmo_timer #(.TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (phase_q == PH_ISSUE),
    .tick    ((phase_q == PH_WAIT) && !port_rdy),
    .limit   (tmo_limit),
    .expired (timed_out)
  );

  clkrc_access_fmt #(.DIV_W(DIV_W)) u_fmt (
    .step  (step_q),
    .code  (code_q),
    .hi    (hi_q),
    .held  (hold_q),
    .addr  (port_addr),
    .we    (port_we),
    .wdata (port_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= ST_DIV;
      code_q  <= '0;
      hi_q    <= 1'b0;
      hold_q  <= '0;
      bad_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      bad_q <= reject;
      case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q <= PH_ISSUE;
          step_q  <= ST_DIV;
          code_q  <= cmd_div_code;
          hi_q    <= cmd_high;
          err_q   <= 1'b0;
        end
        PH_ISSUE: phase_q <= PH_WAIT;
        PH_WAIT: begin
          if (ack) begin
            if (read_step) hold_q <= port_rdata;
            if (last_step) phase_q <= PH_FIN;
            else begin
              phase_q <= PH_ISSUE;
              step_q  <= step_e'(step_q + 3'd1);
            end
          end else if (timed_out) begin
            phase_q <= PH_IDLE;
            err_q   <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy        = !idle_now;
  assign done        = (phase_q == PH_FIN);
  assign port_en     = (phase_q == PH_ISSUE);
  assign bad_cmd     = bad_q;
  assign err_timeout = err_q;

  // ---------------- assertions ----------------
  p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (bad_cmd && !busy && !port_en));
  p_bad_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> !bad_cmd);
  p_div_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (port_en && port_we && port_addr == ADDR_DIV &&
                port_wdata == {{(DATA_W-DIV_W){1'b0}}, $past(cmd_div_code)}));
  p_step_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !last_step) |=> (port_en && step_q == step_e'($past(step_q) + 3'd1)));
  p_synth_rmw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && port_we && port_addr == ADDR_SYNTH) |->
      (((port_wdata ^ hold_q) & ~MASK_SYNTH) == '0 && port_wdata[5] == hi_q));
  p_dll_rmw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && port_we && port_addr == ADDR_DLL) |->
      (((port_wdata ^ hold_q) & ~MASK_DLL) == '0 && port_wdata[7:6] == {2{hi_q}}));
  p_en_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |=> !port_en);
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && last_step) |=> (done && busy));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(code_q) && $stable(hi_q)));
  p_timeout_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |=> (!busy && err_timeout && !done));
  p_stray_rdy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rdy && idle_now && !cmd_valid) |=> !busy);
endmodule

// File: tb/sim_clkmgr_reconfig_seq.sv
module sim_clkmgr_reconfig_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [4:0]  cmd_div_code = '0;
  logic        cmd_high = 1'b0;
  logic [7:0]  tmo_limit = 8'd20;
  logic        busy, done, bad_cmd, err_timeout;
  logic [6:0]  port_addr;
  logic        port_en, port_we;
  logic [15:0] port_wdata;
  logic [15:0] port_rdata = '0;
  logic        port_rdy = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  clkmgr_reconfig_seq u0 (.*);

  // ---------------- device model ----------------
  logic [15:0] r41 = '0, r58 = '0, r52 = '0;
  int          dev_lat = 0;       // -1: never answer
  bit          pend = 0;
  int          pend_cnt = 0;
  logic [6:0]  pa;
  logic        pw;
  logic [15:0] pd;
  bit          stray = 0;
  int          done_seen = 0;

  always @(negedge clk) begin
    port_rdy = 1'b0;
    if (stray) begin
      port_rdy = 1'b1;
      port_rdata = 16'hDEAD;
    end else if (pend && dev_lat >= 0) begin
      if (pend_cnt == 0) begin
        port_rdy = 1'b1;
        pend = 0;
        if (pw) begin
          if (pa == 7'h41) r41 = pd;
          else if (pa == 7'h58) r58 = pd;
          else if (pa == 7'h52) r52 = pd;
        end else begin
          port_rdata = (pa == 7'h41) ? r41 : (pa == 7'h58) ? r58 : 16'hBAD0;
        end
      end else pend_cnt--;
    end
    if (port_en) begin
      pend = 1; pend_cnt = dev_lat; pa = port_addr; pw = port_we; pd = port_wdata;
    end
  end

  // ---------------- reference model ----------------
  int          m_ph = 0;   // 0 idle, 1 issue, 2 wait, 3 fin
  int          m_step = 0, m_cnt = 0;
  bit          m_bad = 0, m_err = 0, m_hi = 0;
  logic [4:0]  m_code = '0;
  logic [15:0] m_hold = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_bad = 0; m_err = 0; m_step = 0; m_hold = '0;
    end else begin
      m_bad = 0;
      if (m_ph == 0) begin
        if (cmd_valid && cmd_div_code == 0) m_bad = 1;
        else if (cmd_valid) begin
          m_ph = 1; m_step = 0; m_code = cmd_div_code; m_hi = cmd_high; m_err = 0;
        end
      end else if (m_ph == 1) begin
        m_ph = 2; m_cnt = 0;
      end else if (m_ph == 2) begin
        if (port_rdy) begin
          if (m_step == 1 || m_step == 3) m_hold = port_rdata;
          if (m_step == 4) m_ph = 3;
          else begin m_step++; m_ph = 1; end
        end else if (m_cnt + 1 >= int'(tmo_limit)) begin
          m_ph = 0; m_err = 1;
        end else m_cnt++;
      end else m_ph = 0;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      logic [6:0]  ea;
      logic        ew;
      logic [15:0] ed;
      chk(busy == (m_ph != 0), "R8 busy", busy, m_ph != 0);
      chk(done == (m_ph == 3), "R8 done", done, m_ph == 3);
      chk(bad_cmd == m_bad, "R2 bad_cmd", bad_cmd, m_bad);
      chk(err_timeout == m_err, "R10 err_timeout", err_timeout, m_err);
      chk(port_en == (m_ph == 1), "R7 port_en", port_en, m_ph == 1);
      if (port_en) begin
        case (m_step)
          0: begin ea = 7'h52; ew = 1; ed = {11'b0, m_code}; end
          1: begin ea = 7'h41; ew = 0; ed = '0; end
          2: begin ea = 7'h41; ew = 1; ed = (m_hold & ~16'h0020) | (m_hi ? 16'h0020 : 16'h0); end
          3: begin ea = 7'h58; ew = 0; ed = '0; end
          default: begin ea = 7'h58; ew = 1; ed = (m_hold & ~16'h00C0) | (m_hi ? 16'h00C0 : 16'h0); end
        endcase
        chk(port_addr == ea, "R4 port_addr", port_addr, ea);
        chk(port_we == ew, "R4 port_we", port_we, ew);
        if (ew) chk(port_wdata == ed, "R5/R6 port_wdata", port_wdata, ed);
      end
      if (done) done_seen++;
    end
  end

  task automatic issue(input logic [4:0] c, input logic h);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_div_code = c; cmd_high = h;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, bad_cmd, err_timeout, port_en} == 5'b0, "R1 reset outputs",
        {busy, done, bad_cmd, err_timeout, port_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R5 R6: high range, fastest replies
    r41 = 16'hA5C3; r58 = 16'h1234; dev_lat = 0;
    d0 = done_seen;
    issue(5'd5, 1'b1); wait_idle();
    chk(r52 == 16'h0005, "R3 divider reg", r52, 16'h0005);
    chk(r41 == 16'hA5E3, "R5 synth reg", r41, 16'hA5E3);
    chk(r58 == 16'h12F4, "R6 dll reg", r58, 16'h12F4);
    chk(done_seen == d0 + 1, "R8 one done", done_seen, d0 + 1);

    // low range, slow replies, top code
    r41 = 16'hFFFF; r58 = 16'hFFFF; dev_lat = 3;
    issue(5'd31, 1'b0); wait_idle();
    chk(r52 == 16'h001F, "R3 divider reg code 31", r52, 16'h001F);
    chk(r41 == 16'hFFDF, "R5 synth reg low", r41, 16'hFFDF);
    chk(r58 == 16'hFF3F, "R6 dll reg low", r58, 16'hFF3F);

    // smallest valid code
    dev_lat = 1;
    issue(5'd1, 1'b1); wait_idle();
    chk(r52 == 16'h0001, "R3 divider reg code 1", r52, 16'h0001);

    // R2 zero code rejected
    d0 = done_seen;
    issue(5'd0, 1'b1); wait_idle();
    chk(r52 == 16'h0001, "R2 divider untouched", r52, 16'h0001);
    chk(done_seen == d0, "R2 no done", done_seen, d0);

    // R9 command while busy ignored
    r41 = 16'h0000; dev_lat = 2; d0 = done_seen;
    issue(5'd7, 1'b1);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_div_code = 5'd9; cmd_high = 1'b0;
    @(negedge clk); cmd_valid = 1'b0;
    wait_idle();
    chk(r52 == 16'h0007, "R9 code kept", r52, 16'h0007);
    chk(r41 == 16'h0020, "R9 range kept", r41, 16'h0020);
    chk(done_seen == d0 + 1, "R9 no restart", done_seen, d0 + 1);

    // R11 stray ready while idle
    stray = 1; @(negedge clk); stray = 0;
    repeat (2) @(negedge clk);
    chk(!busy && !port_en, "R11 stray ready", {busy, port_en}, 0);

    // R10 timeout with no reply
    tmo_limit = 8'd4; dev_lat = -1;
    issue(5'd3, 1'b0); wait_idle();
    chk(err_timeout == 1'b1, "R10 timeout flag", err_timeout, 1);
    chk(r52 == 16'h0007, "R10 no write on timeout", r52, 16'h0007);
    pend = 0;

    // R10 boundary: reply in the last allowed wait cycle, flag clears
    dev_lat = 3; d0 = done_seen;
    issue(5'd12, 1'b1); wait_idle();
    chk(err_timeout == 1'b0, "R10 flag cleared", err_timeout, 0);
    chk(done_seen == d0 + 1, "R10 boundary completes", done_seen, d0 + 1);
    chk(r52 == 16'h000C, "R10 boundary divider", r52, 16'h000C);

    // R10 boundary: one cycle too slow
    tmo_limit = 8'd3;
    issue(5'd13, 1'b1); wait_idle();
    chk(err_timeout == 1'b1, "R10 one past limit", err_timeout, 1);
    pend = 0;

    summary();
  end
endmodule